// File: doc/BRIEF.md
# Double-Buffered Serial DMA Channel

This block is the memory-side engine for a serial peripheral. Software sets up a buffer for each direction, an address and a count of transfer units. While one buffer is in progress, software can queue a second buffer for the same direction. Receive moves words from the peripheral's receive data register into memory. Transmit moves words from memory into the peripheral's transmit data register.

When a direction's current count runs out and a queued buffer exists, the queued buffer moves into the current slot with no software action. Software can then queue the next buffer without the stream stopping. Two flags per direction go to the peripheral's status logic:
- one reports that the current buffer is finished;
- the other reports that no work remains in either slot.

The channel issues single-unit requests on a request/grant memory port. Receive has priority when both directions are ready.

Top module: `dbl_dma_chan`

## Requirements
- R1: After reset all pointers and counts are zero, both directions are disabled, `bus_req` is low, and all four end/exhausted flags are high.
- R2: A write through the register port loads the addressed register in the next cycle, and reads return it. The register word offsets from `REG_BASE` (0x100) are:
  - 0x00 receive pointer, 0x04 receive count, 0x08 transmit pointer, 0x0C transmit count;
  - 0x10 queued receive pointer, 0x14 queued receive count, 0x18 queued transmit pointer, 0x1C queued transmit count;
  - 0x20 control, 0x24 enable state (bit 0 receive, bit 8 transmit).
  
  Counts are 16 bits wide and read back zero-extended.
- R3: In the control word:
  - bit 0 enables receive and bit 1 disables it;
  - bit 8 enables transmit and bit 9 disables it;
  - if enable and disable for one direction are set in the same write, disable wins;
  - a disabled direction makes no requests.
- R4: A receive request (`bus_req` high, `bus_we` high) is made when receive is enabled, its current count is non-zero and `periph_rx_full` is high. It carries the receive pointer on `bus_addr` and `periph_rx_data` on `bus_wdata`. A granted receive unit pulses `rx_take`.
- R5: A transmit request (`bus_req` high, `bus_we` low) needs transmit enabled, a non-zero count and `periph_tx_empty` high. A granted transmit unit pulses `tx_load` and presents `bus_rdata` on `tx_data`.
- R6: Each granted unit decrements the current count by one. It advances the pointer by 1 when `wide_words` is low, or by 2 when it is high. `bus_hsize` follows `wide_words`.
- R7: When both directions are ready in the same cycle, receive is requested and granted first.
- R8: When a current count is zero and the queued count is non-zero, the next clock edge copies the queued pointer and count into the current slot and clears the queued count. This happens only in a cycle with no register write to that direction.
- R9: The end flag of a direction is high exactly when its current count is zero. Its exhausted flag is high when both its current and queued counts are zero. With a zero queued count, the channel stops once the current count runs out.
- R10: A register write to a current count in the same cycle as a granted unit for that direction wins over the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| wide_words | input | 1 | High: one unit is a halfword, step 2 |
| periph_rx_full | input | 1 | Peripheral holds a received word |
| periph_rx_data | input | 16 | Peripheral received word |
| periph_tx_empty | input | 1 | Peripheral can accept a word |
| rx_take | output | 1 | Receive word consumed this cycle |
| tx_load | output | 1 | Load `tx_data` into the peripheral |
| tx_data | output | 16 | Word for the peripheral |
| bus_req | output | 1 | Memory access request |
| bus_we | output | 1 | 1 memory write (receive), 0 read (transmit) |
| bus_addr | output | 32 | Memory address |
| bus_hsize | output | 1 | Unit is a halfword |
| bus_wdata | output | 16 | Memory write data |
| bus_rdata | input | 16 | Memory read data |
| bus_gnt | input | 1 | Access completes this cycle |
| rx_end_flag | output | 1 | Current receive count is zero |
| rx_bufs_done | output | 1 | Both receive counts are zero |
| tx_end_flag | output | 1 | Current transmit count is zero |
| tx_bufs_done | output | 1 | Both transmit counts are zero |

## Verification
The hardest situation to reach is the one-cycle window in which a current count has just reached zero while a queued buffer is pending. In that cycle the end flag is high, the exhausted flag is low and no request is made. The stimulus gets there by queueing a second receive buffer behind a one-unit first buffer and granting exactly one unit. The flags are then sampled before and after the promotion edge. A separate scenario lands a count write on the same edge as a grant to prove which one wins.

// File: rtl/dbl_dma_pkg.sv
package dbl_dma_pkg;

    localparam int PTR_W  = 32;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;
    localparam int N_SIDE = 2;
    localparam int SIDE_RX = 0;
    localparam int SIDE_TX = 1;

    typedef enum logic [3:0] {
        IDX_RX_PTR  = 4'd0,
        IDX_RX_CNT  = 4'd1,
        IDX_TX_PTR  = 4'd2,
        IDX_TX_CNT  = 4'd3,
        IDX_RXQ_PTR = 4'd4,
        IDX_RXQ_CNT = 4'd5,
        IDX_TXQ_PTR = 4'd6,
        IDX_TXQ_CNT = 4'd7,
        IDX_CTRL    = 4'd8,
        IDX_STATE   = 4'd9
    } reg_idx_e;

    localparam int N_REGS = 10;

    // control word bit positions (decoded by software, so fixed)
    localparam int CB_RX_ON  = 0;
    localparam int CB_RX_OFF = 1;
    localparam int CB_TX_ON  = 8;
    localparam int CB_TX_OFF = 9;

    // per-slot write strobes within a direction
    typedef struct packed {
        logic q_cnt;
        logic q_ptr;
        logic cur_cnt;
        logic cur_ptr;
    } side_wr_t;

    typedef struct packed {
        logic [PTR_W-1:0] cur_ptr;
        logic [CNT_W-1:0] cur_cnt;
        logic [PTR_W-1:0] q_ptr;
        logic [CNT_W-1:0] q_cnt;
    } side_state_t;

    function automatic logic [PTR_W-1:0] unit_step(input logic wide);
        return wide ? PTR_W'(2) : PTR_W'(1);
    endfunction

    function automatic logic [3:0] cur_ptr_idx(input int side);
        return 4'(2 * side);
    endfunction

    function automatic logic [3:0] q_ptr_idx(input int side);
        return 4'(4 + 2 * side);
    endfunction

endpackage

// File: rtl/dbl_dma_ctrl.sv
module dbl_dma_ctrl
    import dbl_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr,
    input  logic [31:0] wdata,
    output logic [N_SIDE-1:0] dir_en
);

    logic [N_SIDE-1:0] on_req;
    logic [N_SIDE-1:0] off_req;

    always_comb begin
        on_req  = '0;
        off_req = '0;
        on_req[SIDE_RX]  = wdata[CB_RX_ON];
        off_req[SIDE_RX] = wdata[CB_RX_OFF];
        on_req[SIDE_TX]  = wdata[CB_TX_ON];
        off_req[SIDE_TX] = wdata[CB_TX_OFF];
    end

    for (genvar s = 0; s < N_SIDE; s++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst) begin
                dir_en[s] <= 1'b0;
            end else if (ctrl_wr) begin
                if (off_req[s]) begin
                    dir_en[s] <= 1'b0;
                end else if (on_req[s]) begin
                    dir_en[s] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dbl_dma_side.sv
module dbl_dma_side
    import dbl_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  side_wr_t    wr,
    input  logic [31:0] wdata,
    input  logic        wide,
    input  logic        enable,
    input  logic        ready,
    input  logic        grant,
    output side_state_t st,
    output logic        req,
    output logic        end_flag,
    output logic        done_flag
);

    logic cur_zero;
    logic q_zero;
    logic touched;
    logic promote;
    logic step;

    assign cur_zero  = (st.cur_cnt == '0);
    assign q_zero    = (st.q_cnt == '0);
    assign touched   = |wr;
    assign promote   = cur_zero && !q_zero && !touched;
    assign step      = grant && !cur_zero;
    assign req       = enable && !cur_zero && ready;
    assign end_flag  = cur_zero;
    assign done_flag = cur_zero && q_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            // current pointer
            if (wr.cur_ptr) begin
                st.cur_ptr <= wdata[PTR_W-1:0];
            end else if (promote) begin
                st.cur_ptr <= st.q_ptr;
            end else if (step) begin
                st.cur_ptr <= st.cur_ptr + unit_step(wide);
            end
            // current count
            if (wr.cur_cnt) begin
                st.cur_cnt <= wdata[CNT_W-1:0];
            end else if (promote) begin
                st.cur_cnt <= st.q_cnt;
            end else if (step) begin
                st.cur_cnt <= st.cur_cnt - CNT_W'(1);
            end
            // queued slot
            if (wr.q_ptr) begin
                st.q_ptr <= wdata[PTR_W-1:0];
            end
            if (wr.q_cnt) begin
                st.q_cnt <= wdata[CNT_W-1:0];
            end else if (promote) begin
                st.q_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/dbl_dma_arb.sv
module dbl_dma_arb
    import dbl_dma_pkg::*;
(
    input  logic [N_SIDE-1:0] req,
    input  logic              bus_gnt,
    output logic [N_SIDE-1:0] gnt,
    output logic              pick_rx,
    output logic              any_req
);

    assign pick_rx = req[SIDE_RX];
    assign any_req = |req;

    always_comb begin
        gnt = '0;
        if (bus_gnt) begin
            if (pick_rx) begin
                gnt[SIDE_RX] = 1'b1;
            end else if (req[SIDE_TX]) begin
                gnt[SIDE_TX] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dbl_dma_chan.sv
module dbl_dma_chan
    import dbl_dma_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int REG_BASE = 'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              wide_words,
    input  logic              periph_rx_full,
    input  logic [15:0]       periph_rx_data,
    input  logic              periph_tx_empty,
    output logic              rx_take,
    output logic              tx_load,
    output logic [15:0]       tx_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [31:0]       bus_addr,
    output logic              bus_hsize,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_gnt,
    output logic              rx_end_flag,
    output logic              rx_bufs_done,
    output logic              tx_end_flag,
    output logic              tx_bufs_done
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REG_BASE);

    logic [ADDR_W-1:0] offs;
    logic              in_win;
    logic [3:0]        idx;
    logic              ctrl_wr;

    side_state_t       st       [N_SIDE];
    side_wr_t          side_wr  [N_SIDE];
    logic [N_SIDE-1:0] side_req;
    logic [N_SIDE-1:0] side_gnt;
    logic [N_SIDE-1:0] side_end;
    logic [N_SIDE-1:0] side_done;
    logic [N_SIDE-1:0] dir_en;
    logic [N_SIDE-1:0] ready;
    logic              pick_rx;
    logic              any_req;

    // register address decode
    assign offs   = reg_addr - BASE_A;
    assign in_win = (reg_addr >= BASE_A) && (offs[1:0] == 2'b00)
                    && ((offs >> 2) < ADDR_W'(N_REGS));
    assign idx    = in_win ? offs[5:2] : 4'hF;
    assign ctrl_wr = reg_wr && (idx == IDX_CTRL);

    assign ready[SIDE_RX] = periph_rx_full;
    assign ready[SIDE_TX] = periph_tx_empty;

    dbl_dma_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (ctrl_wr),
        .wdata   (reg_wdata),
        .dir_en  (dir_en)
    );

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        always_comb begin
            side_wr[s].cur_ptr = reg_wr && (idx == cur_ptr_idx(s));
            side_wr[s].cur_cnt = reg_wr && (idx == cur_ptr_idx(s) + 4'd1);
            side_wr[s].q_ptr   = reg_wr && (idx == q_ptr_idx(s));
            side_wr[s].q_cnt   = reg_wr && (idx == q_ptr_idx(s) + 4'd1);
        end

        dbl_dma_side u_side (
            .clk       (clk),
            .rst       (rst),
            .wr        (side_wr[s]),
            .wdata     (reg_wdata),
            .wide      (wide_words),
            .enable    (dir_en[s]),
            .ready     (ready[s]),
            .grant     (side_gnt[s]),
            .st        (st[s]),
            .req       (side_req[s]),
            .end_flag  (side_end[s]),
            .done_flag (side_done[s])
        );
    end

    dbl_dma_arb u_arb (
        .req     (side_req),
        .bus_gnt (bus_gnt),
        .gnt     (side_gnt),
        .pick_rx (pick_rx),
        .any_req (any_req)
    );

    // bus side
    assign bus_req   = any_req;
    assign bus_we    = pick_rx;
    assign bus_addr  = pick_rx ? st[SIDE_RX].cur_ptr : st[SIDE_TX].cur_ptr;
    assign bus_hsize = wide_words;
    assign bus_wdata = periph_rx_data;
    assign rx_take   = side_gnt[SIDE_RX];
    assign tx_load   = side_gnt[SIDE_TX];
    assign tx_data   = bus_rdata;

    assign rx_end_flag  = side_end[SIDE_RX];
    assign rx_bufs_done = side_done[SIDE_RX];
    assign tx_end_flag  = side_end[SIDE_TX];
    assign tx_bufs_done = side_done[SIDE_TX];

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (idx)
            IDX_RX_PTR:  reg_rdata = st[SIDE_RX].cur_ptr;
            IDX_RX_CNT:  reg_rdata = 32'(st[SIDE_RX].cur_cnt);
            IDX_TX_PTR:  reg_rdata = st[SIDE_TX].cur_ptr;
            IDX_TX_CNT:  reg_rdata = 32'(st[SIDE_TX].cur_cnt);
            IDX_RXQ_PTR: reg_rdata = st[SIDE_RX].q_ptr;
            IDX_RXQ_CNT: reg_rdata = 32'(st[SIDE_RX].q_cnt);
            IDX_TXQ_PTR: reg_rdata = st[SIDE_TX].q_ptr;
            IDX_TXQ_CNT: reg_rdata = 32'(st[SIDE_TX].q_cnt);
            IDX_STATE: begin
                reg_rdata[CB_RX_ON] = dir_en[SIDE_RX];
                reg_rdata[CB_TX_ON] = dir_en[SIDE_TX];
            end
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbl_dma_chan_chk.sv
module dbl_dma_chan_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_we,
    input logic        bus_gnt,
    input logic        rx_full,
    input logic        rx_en,
    input logic        tx_en,
    input logic        ctrl_wr,
    input logic        off_rx_bit,
    input logic        rx_touch,
    input logic [15:0] rx_cnt,
    input logic [15:0] rx_qcnt,
    input logic [15:0] tx_cnt,
    input logic        rx_end,
    input logic        rx_done
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rx_cnt == 16'd0 && tx_cnt == 16'd0 && !rx_en && !tx_en && !bus_req));

    p_disable_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && off_rx_bit) |=> !rx_en);

    p_rx_req_cond_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |-> (rx_full && rx_en && rx_cnt != 16'd0));

    p_rx_step_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_gnt && !rx_touch) |=> rx_cnt == $past(rx_cnt) - 16'd1);

    p_rx_first_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_en && rx_full && rx_cnt != 16'd0) |-> (bus_req && bus_we));

    p_promote_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt == 16'd0 && rx_qcnt != 16'd0 && !rx_touch)
        |=> (rx_cnt == $past(rx_qcnt) && rx_qcnt == 16'd0));

    p_flags_r9: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> rx_end);

endmodule

bind dbl_dma_chan dbl_dma_chan_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_gnt    (bus_gnt),
    .rx_full    (periph_rx_full),
    .rx_en      (dir_en[0]),
    .tx_en      (dir_en[1]),
    .ctrl_wr    (ctrl_wr),
    .off_rx_bit (reg_wdata[1]),
    .rx_touch   (|side_wr[0]),
    .rx_cnt     (st[0].cur_cnt),
    .rx_qcnt    (st[0].q_cnt),
    .tx_cnt     (st[1].cur_cnt),
    .rx_end     (rx_end_flag),
    .rx_done    (rx_bufs_done)
);

// File: tb/dbl_dma_chan_test.sv
module dbl_dma_chan_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wide_words = 1'b0;
    logic        periph_rx_full = 1'b0;
    logic [15:0] periph_rx_data = 16'h0;
    logic        periph_tx_empty = 1'b0;
    logic        rx_take, tx_load, bus_req, bus_we, bus_hsize;
    logic [15:0] tx_data, bus_wdata;
    logic [15:0] bus_rdata = 16'h0;
    logic [31:0] bus_addr;
    logic        bus_gnt = 1'b0;
    logic        rx_end_flag, rx_bufs_done, tx_end_flag, tx_bufs_done;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [11:0] A_RXP = 12'h100, A_RXC = 12'h104, A_TXP = 12'h108, A_TXC = 12'h10C;
    localparam logic [11:0] A_RXQP = 12'h110, A_RXQC = 12'h114, A_TXQP = 12'h118, A_TXQC = 12'h11C;
    localparam logic [11:0] A_CTRL = 12'h120, A_STATE = 12'h124;

    always #5 clk = ~clk;

    dbl_dma_chan uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wide_words(wide_words),
        .periph_rx_full(periph_rx_full), .periph_rx_data(periph_rx_data),
        .periph_tx_empty(periph_tx_empty), .rx_take(rx_take), .tx_load(tx_load),
        .tx_data(tx_data), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_hsize(bus_hsize), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_gnt(bus_gnt), .rx_end_flag(rx_end_flag), .rx_bufs_done(rx_bufs_done),
        .tx_end_flag(tx_end_flag), .tx_bufs_done(tx_bufs_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_all();
        wr(A_CTRL, 32'h202);
        wr(A_RXQC, 0); wr(A_TXQC, 0); wr(A_RXC, 0); wr(A_TXC, 0);
        periph_rx_full = 1'b0; periph_tx_empty = 1'b0; bus_gnt = 1'b0;
        wide_words = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        #1;
        check("R1 bus_req", 32'(bus_req), 0);
        check("R1 flags", {28'h0, rx_end_flag, rx_bufs_done, tx_end_flag, tx_bufs_done}, 32'hF);
        rd(A_RXC, v); check("R1 rx cnt", v, 0);
        rd(A_TXP, v); check("R1 tx ptr", v, 0);
        rd(A_STATE, v); check("R1 enables", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_RXP, 32'hA000_0010); wr(A_RXC, 32'h0001_0007);
        wr(A_TXP, 32'hB000_0020); wr(A_TXC, 32'd9);
        wr(A_RXQP, 32'hC000_0030); wr(A_RXQC, 32'd11);
        wr(A_TXQP, 32'hD000_0040); wr(A_TXQC, 32'd13);
        rd(A_RXP, v);  check("R2 rx ptr", v, 32'hA000_0010);
        rd(A_RXC, v);  check("R2 rx cnt 16b", v, 32'd7);
        rd(A_TXP, v);  check("R2 tx ptr", v, 32'hB000_0020);
        rd(A_TXC, v);  check("R2 tx cnt", v, 32'd9);
        rd(A_RXQP, v); check("R2 rx q ptr", v, 32'hC000_0030);
        rd(A_RXQC, v); check("R2 rx q cnt", v, 32'd11);
        rd(A_TXQP, v); check("R2 tx q ptr", v, 32'hD000_0040);
        rd(A_TXQC, v); check("R2 tx q cnt", v, 32'd13);
        check("R9 flags nonzero", {30'h0, rx_end_flag, rx_bufs_done}, 0);
        clear_all();
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(A_CTRL, 32'h101); rd(A_STATE, v); check("R3 both on", v, 32'h101);
        wr(A_CTRL, 32'h002); rd(A_STATE, v); check("R3 rx off", v, 32'h100);
        wr(A_CTRL, 32'h303); rd(A_STATE, v); check("R3 disable wins", v, 32'h0);
        wr(A_RXC, 32'd2);
        @(negedge clk); periph_rx_full = 1'b1; #1;
        check("R3 disabled no req", 32'(bus_req), 0);
        clear_all();
    endtask

    task automatic t_rx_narrow();
        logic [31:0] v;
        wr(A_RXP, 32'h1000); wr(A_RXC, 32'd3); wr(A_CTRL, 32'h1);
        @(negedge clk); periph_rx_full = 1'b1; periph_rx_data = 16'h5A5A; #1;
        check("R4 req", {29'h0, bus_req, bus_we, bus_hsize}, 32'b110);
        check("R4 addr", bus_addr, 32'h1000);
        check("R4 wdata", 32'(bus_wdata), 32'h5A5A);
        @(negedge clk); bus_gnt = 1'b1; #1;
        check("R4 take", 32'(rx_take), 1);
        @(negedge clk); #1;
        rd(A_RXP, v); check("R6 ptr +1", v, 32'h1001);
        rd(A_RXC, v); check("R6 cnt -1", v, 32'd2);
        @(negedge clk); @(negedge clk); bus_gnt = 1'b0; #1;
        rd(A_RXC, v); check("R9 rx cnt 0", v, 0);
        check("R9 stop", {29'h0, bus_req, rx_end_flag, rx_bufs_done}, 32'b011);
        clear_all();
    endtask

    task automatic t_tx_wide();
        logic [31:0] v;
        wide_words = 1'b1;
        wr(A_TXP, 32'h2000); wr(A_TXC, 32'd2); wr(A_CTRL, 32'h100);
        @(negedge clk); periph_tx_empty = 1'b1; bus_rdata = 16'hBEEF; bus_gnt = 1'b1; #1;
        check("R5 req rd", {29'h0, bus_req, bus_we, bus_hsize}, 32'b101);
        check("R5 load", {15'h0, tx_load, tx_data}, 32'h1_BEEF);
        check("R5 addr", bus_addr, 32'h2000);
        @(negedge clk); bus_gnt = 1'b0; #1;
        rd(A_TXP, v); check("R6 wide ptr +2", v, 32'h2002);
        rd(A_TXC, v); check("R6 wide cnt", v, 32'd1);
        clear_all();
    endtask

    task automatic t_priority();
        wr(A_RXP, 32'h3000); wr(A_RXC, 32'd1);
        wr(A_TXP, 32'h4000); wr(A_TXC, 32'd1);
        wr(A_CTRL, 32'h101);
        @(negedge clk); periph_rx_full = 1'b1; periph_tx_empty = 1'b1; bus_gnt = 1'b1; #1;
        check("R7 rx first", {30'h0, bus_we, rx_take}, 32'b11);
        check("R7 rx addr", bus_addr, 32'h3000);
        check("R7 no tx load", 32'(tx_load), 0);
        @(negedge clk); #1;
        check("R7 tx next", {30'h0, bus_we, tx_load}, 32'b01);
        check("R7 tx addr", bus_addr, 32'h4000);
        @(negedge clk); bus_gnt = 1'b0;
        clear_all();
    endtask

    task automatic t_promote();
        logic [31:0] v;
        wr(A_RXP, 32'h10); wr(A_RXC, 32'd1);
        wr(A_RXQP, 32'h40); wr(A_RXQC, 32'd2);
        wr(A_CTRL, 32'h1);
        @(negedge clk); periph_rx_full = 1'b1; bus_gnt = 1'b1;
        @(negedge clk); bus_gnt = 1'b0; #1;
        check("R9 end only", {29'h0, bus_req, rx_end_flag, rx_bufs_done}, 32'b010);
        @(negedge clk); #1;
        rd(A_RXP, v);  check("R8 ptr copied", v, 32'h40);
        rd(A_RXC, v);  check("R8 cnt copied", v, 32'd2);
        rd(A_RXQC, v); check("R8 q cleared", v, 0);
        check("R8 end low", 32'(rx_end_flag), 0);
        bus_gnt = 1'b1;
        @(negedge clk); @(negedge clk); bus_gnt = 1'b0;
        @(negedge clk); @(negedge clk); #1;
        rd(A_RXP, v); check("R9 ptr end", v, 32'h42);
        check("R9 exhausted", {29'h0, bus_req, rx_end_flag, rx_bufs_done}, 32'b011);
        clear_all();
    endtask

    task automatic t_override();
        logic [31:0] v;
        wr(A_RXP, 32'h300); wr(A_RXC, 32'd5); wr(A_CTRL, 32'h1);
        @(negedge clk); periph_rx_full = 1'b1; bus_gnt = 1'b1;
        reg_wr = 1'b1; reg_addr = A_RXC; reg_wdata = 32'd9;
        @(negedge clk); reg_wr = 1'b0; bus_gnt = 1'b0; #1;
        rd(A_RXC, v); check("R10 write wins", v, 32'd9);
        rd(A_RXP, v); check("R10 ptr stepped", v, 32'h301);
        clear_all();
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_ctrl();
        t_rx_narrow();
        t_tx_wide();
        t_priority();
        t_promote();
        t_override();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule